// File: doc/BRIEF.md
# Dual-Master Maskable Interrupt and Status Registers

This block sits behind a serial register interface that two upstream masters share. For each master it keeps an interrupt-enable (mask) register and a read-only status register. It drives one active-low interrupt line per master. Four sources feed each line: a shared active-low interrupt arriving from the downstream side, a per-master "bus taken away" event, a per-master "bus initialization finished" event, and a per-master functional-test level. Each master masks each source for its own line only. So one master can ignore the downstream interrupt while the other still sees it.

The serial protocol engine is not part of this block. It presents each transaction as strobes: a command byte, data-byte writes that need an acknowledge decision in the same cycle, and data-byte reads that need the byte in the same cycle. A selector input says which master is talking. Bits [1:0] of the command byte pick the register, and bit 4 turns on pointer auto-increment. The pointer climbs after each data byte and then stays on the status register. The control register lives in a neighbouring block. This block decodes its address, passes write strobes out and passes read data in.

Top module: `dual_irq_regs`

## Requirements
- R1: The command byte loads the accessing master's pointer from bits [1:0], which are decoded as follows:
  - 00 selects the enable register.
  - 01 selects the control register.
  - 10 selects the status register.
  - 11 also selects the status register.
  Bit 4 of the command byte set to 1 turns auto-increment on for the data bytes that follow.
- R2: With auto-increment on, each data-byte write or read advances the pointer by one. A pointer at 10 stays at 10. With auto-increment off, the pointer does not move.
- R3: A write to the enable register or the control register is acknowledged (`wr_ack`=1).
  - An enable write stores bits [3:0] of the data byte. The enable register reads back as those four bits with zeros above them.
  - A control write raises `ctl_we` for that cycle, with `ctl_wd` equal to the data byte.
- R4: A write while the pointer is at the status register is not acknowledged and changes no state. The third data byte of an auto-increment write that began at the enable register is therefore not acknowledged.
- R5: When `ds_irq_n` is low and neither master has bit 0 of its enable register set, both `irq_n` bits go low.
- R6: Bit 0 of a master's enable register masks the downstream source for that master's `irq_n` bit only.
- R7: The status byte carries four bits:
  - bit 0: the downstream interrupt is active (the inverse of `ds_irq_n`).
  - bit 1: bus lost.
  - bit 2: bus initialization finished.
  - bit 3: test.
  Bits 7:4 read as 0. Reading the status byte leaves bits 0 and 3 unchanged; they follow their inputs live.
- R8: Bits 1 and 2 of the status byte behave as follows:
  - A one-cycle pulse on `ev_lost`/`ev_init` for a master sets that master's bit 1 (from `ev_lost`) or bit 2 (from `ev_init`).
  - The bit clears when that same master reads its status register. Reads by the other master do not clear it.
  - If an event arrives in the same cycle as the clearing read, the bit stays set.
- R9: Each `irq_n` bit is registered. One clock edge after a given cycle, the bit is low exactly when, in that cycle, some status bit of that master was 1 and the enable bit at the same position was 0. Enable bits use the same positions as the status bits.
- R10: After reset:
  - both `irq_n` bits are high;
  - enable registers are 0;
  - status bits 1 and 2 are 0;
  - pointers are at 00 with auto-increment off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_sel | input | 1 | Index of the master making the access |
| cmd_vld | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| wr_vld | input | 1 | Data-byte write strobe |
| wr_byte | input | 8 | Data byte being written |
| wr_ack | output | 1 | Acknowledge decision for the write in this cycle |
| rd_vld | input | 1 | Data-byte read strobe |
| rd_byte | output | 8 | Byte at the accessing master's pointer |
| ctl_rd_byte | input | 8 | Control register contents from the neighbouring block |
| ctl_we | output | 1 | Control register write strobe |
| ctl_wd | output | 8 | Control register write data |
| ds_irq_n | input | 1 | Shared downstream interrupt, active low |
| ev_lost | input | 2 | Per-master bus-lost event pulse |
| ev_init | input | 2 | Per-master bus-initialization-done event pulse |
| tst_lvl | input | 2 | Per-master functional-test request level |
| irq_n | output | 2 | Per-master interrupt output, active low |

## Verification
Two functions can fall in the same cycle:
- a master's status read, which clears its sticky bits;
- a new bus-lost or initialization event for that same master.

The bench raises the event pulse during the very read strobe. It then judges the outcome two ways:
- The byte returned in that cycle shows the old value.
- The next read shows the bit still set, and the interrupt line stays low.

A reference model, updated on each clock from the requirements, is compared with every `irq_n` bit on every cycle, so races between mask writes and arriving sources are covered as well.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int SRC_W   = 4;
    localparam int AI_BIT  = 4;
    localparam int SRC_DS  = 0;
    localparam int SRC_LST = 1;
    localparam int SRC_INI = 2;
    localparam int SRC_TST = 3;

    typedef enum logic [1:0] {
        PTR_IE   = 2'b00,
        PTR_CTL  = 2'b01,
        PTR_STAT = 2'b10,
        PTR_RSV  = 2'b11
    } ptr_e;

    function automatic logic [1:0] ptr_clamp(input logic [1:0] code);
        return (code == 2'b11) ? 2'b10 : code;
    endfunction

    function automatic logic [1:0] ptr_step(input logic [1:0] p);
        return (p >= 2'b10) ? 2'b10 : p + 2'b01;
    endfunction
endpackage

// File: rtl/irqsel_ptr.sv
module irqsel_ptr
    import irqsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       cmd_vld,
    input  logic [1:0] cmd_code,
    input  logic       cmd_ai,
    input  logic       wr_vld,
    input  logic       rd_vld,
    output logic [1:0] ptr,
    output logic       wr_ok
);
    typedef struct packed {
        logic [1:0] ptr;
        logic       ai;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (cmd_vld) begin
                st_d.ptr = ptr_clamp(cmd_code);
                st_d.ai  = cmd_ai;
            end else if ((wr_vld || rd_vld) && st_q.ai) begin
                st_d.ptr = ptr_step(st_q.ptr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr   = st_q.ptr;
    assign wr_ok = (st_q.ptr != PTR_STAT);

    // R1: command code 01 lands on the control register
    a_r1_cmd_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd_vld && cmd_code == 2'b01) |=> (ptr == PTR_CTL));
    // R2: auto-increment steps from enable to control
    a_r2_ai_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !cmd_vld && (wr_vld || rd_vld) && st_q.ai && ptr == PTR_IE) |=> (ptr == PTR_CTL));
    // R2: auto-increment sticks at status
    a_r2_ai_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !cmd_vld && ptr == PTR_STAT) |=> (ptr == PTR_STAT));
endmodule

// File: rtl/irqsel_src.sv
module irqsel_src
    import irqsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_we,
    input  logic [SRC_W-1:0] ie_wd,
    input  logic             stat_rd,
    input  logic             ds_act,
    input  logic             ev_lost,
    input  logic             ev_init,
    input  logic             tst,
    output logic [SRC_W-1:0] ie,
    output logic [SRC_W-1:0] stat,
    output logic             irq_n
);
    typedef struct packed {
        logic [SRC_W-1:0] ie;
        logic             lost;
        logic             init;
        logic             irq_n;
    } sst_t;

    sst_t st_d, st_q;
    logic [SRC_W-1:0] stat_now;

    always_comb begin
        stat_now          = '0;
        stat_now[SRC_DS]  = ds_act;
        stat_now[SRC_LST] = st_q.lost;
        stat_now[SRC_INI] = st_q.init;
        stat_now[SRC_TST] = tst;

        st_d       = st_q;
        if (ie_we) st_d.ie = ie_wd;
        st_d.lost  = ev_lost | (st_q.lost & ~stat_rd);
        st_d.init  = ev_init | (st_q.init & ~stat_rd);
        st_d.irq_n = ~|(stat_now & ~st_q.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie    = st_q.ie;
    assign stat  = stat_now;
    assign irq_n = st_q.irq_n;

    // R5: unmasked downstream source pulls the line low
    a_r5_ds_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_act && !st_q.ie[SRC_DS]) |=> !irq_n);
    // R9: fully masked line stays released
    a_r9_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.ie) |=> irq_n);
    // R8: read clears a sticky bit when no new event arrives
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ev_lost) |=> !st_q.lost);
    // R8: an event wins over a concurrent read
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_init |=> st_q.init);
endmodule

// File: rtl/dual_irq_regs.sv
module dual_irq_regs
    import irqsel_pkg::*;
#(
    parameter  int NMST  = 2,
    localparam int SEL_W = (NMST > 1) ? $clog2(NMST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic             cmd_vld,
    input  logic [7:0]       cmd_byte,
    input  logic             wr_vld,
    input  logic [7:0]       wr_byte,
    output logic             wr_ack,
    input  logic             rd_vld,
    output logic [7:0]       rd_byte,
    input  logic [7:0]       ctl_rd_byte,
    output logic             ctl_we,
    output logic [7:0]       ctl_wd,
    input  logic             ds_irq_n,
    input  logic [NMST-1:0]  ev_lost,
    input  logic [NMST-1:0]  ev_init,
    input  logic [NMST-1:0]  tst_lvl,
    output logic [NMST-1:0]  irq_n
);
    logic [1:0]       ptr_v  [NMST];
    logic             wok_v  [NMST];
    logic [SRC_W-1:0] ie_v   [NMST];
    logic [SRC_W-1:0] stat_v [NMST];
    logic             unused_cmd;

    assign unused_cmd = ^{cmd_byte[7:5], cmd_byte[3:2]};

    for (genvar m = 0; m < NMST; m++) begin : g_mst
        localparam logic [SEL_W-1:0] MID = SEL_W'(m);
        logic sel_m;
        assign sel_m = (acc_sel == MID);

        irqsel_ptr u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel_m),
            .cmd_vld  (cmd_vld),
            .cmd_code (cmd_byte[1:0]),
            .cmd_ai   (cmd_byte[AI_BIT]),
            .wr_vld   (wr_vld),
            .rd_vld   (rd_vld),
            .ptr      (ptr_v[m]),
            .wr_ok    (wok_v[m])
        );

        irqsel_src u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .ie_we   (sel_m && wr_vld && !cmd_vld && ptr_v[m] == PTR_IE),
            .ie_wd   (wr_byte[SRC_W-1:0]),
            .stat_rd (sel_m && rd_vld && !cmd_vld && ptr_v[m] == PTR_STAT),
            .ds_act  (~ds_irq_n),
            .ev_lost (ev_lost[m]),
            .ev_init (ev_init[m]),
            .tst     (tst_lvl[m]),
            .ie      (ie_v[m]),
            .stat    (stat_v[m]),
            .irq_n   (irq_n[m])
        );

        // R4: a write aimed at status leaves the enable register alone
        a_r4_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_m && wr_vld && !cmd_vld && ptr_v[m] == PTR_STAT) |=> $stable(ie_v[m]));
    end

    always_comb begin
        wr_ack = wr_vld && wok_v[acc_sel];
        ctl_we = wr_vld && !cmd_vld && (ptr_v[acc_sel] == PTR_CTL);
        ctl_wd = wr_byte;
        case (ptr_v[acc_sel])
            PTR_IE:  rd_byte = {{(8-SRC_W){1'b0}}, ie_v[acc_sel]};
            PTR_CTL: rd_byte = ctl_rd_byte;
            default: rd_byte = {{(8-SRC_W){1'b0}}, stat_v[acc_sel]};
        endcase
    end

    // R4: no acknowledge and no control strobe at the status register
    a_r4_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && ptr_v[acc_sel] == PTR_STAT) |-> (!wr_ack && !ctl_we));
endmodule

// File: tb/dual_irq_regs_bench.sv
module dual_irq_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_sel = 1'b0;
    logic       cmd_vld = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       wr_vld = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_ack;
    logic       rd_vld = 1'b0;
    logic [7:0] rd_byte;
    logic [7:0] ctl_rd_byte = 8'h5A;
    logic       ctl_we;
    logic [7:0] ctl_wd;
    logic       ds_irq_n = 1'b1;
    logic [1:0] ev_lost = '0;
    logic [1:0] ev_init = '0;
    logic [1:0] tst_lvl = '0;
    logic [1:0] irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_irq_regs u_dual_irq_regs (
        .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .cmd_vld(cmd_vld),
        .cmd_byte(cmd_byte), .wr_vld(wr_vld), .wr_byte(wr_byte), .wr_ack(wr_ack),
        .rd_vld(rd_vld), .rd_byte(rd_byte), .ctl_rd_byte(ctl_rd_byte),
        .ctl_we(ctl_we), .ctl_wd(ctl_wd), .ds_irq_n(ds_irq_n), .ev_lost(ev_lost),
        .ev_init(ev_init), .tst_lvl(tst_lvl), .irq_n(irq_n)
    );

    // reference model, written from the requirements
    int       m_ptr [2];
    bit       m_ai  [2];
    bit [3:0] m_ie  [2];
    bit       m_lost[2];
    bit       m_init[2];
    bit [1:0] m_irq;

    function automatic bit [7:0] m_stat(input int m);
        return {4'b0, tst_lvl[m], m_init[m], m_lost[m], ~ds_irq_n};
    endfunction

    function automatic bit [7:0] m_rd(input int m);
        if (m_ptr[m] == 0)      return {4'b0, m_ie[m]};
        else if (m_ptr[m] == 1) return ctl_rd_byte;
        else                    return m_stat(m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < 2; m++) begin
                m_ptr[m] = 0; m_ai[m] = 0; m_ie[m] = 0; m_lost[m] = 0; m_init[m] = 0;
            end
            m_irq = 2'b11;
        end else begin
            for (int m = 0; m < 2; m++) begin
                bit sel;
                bit clr;
                bit [3:0] st;
                sel = (acc_sel == m[0]);
                st  = m_stat(m)[3:0];
                m_irq[m] = ((st & ~m_ie[m]) == 4'b0);
                clr = sel && rd_vld && !cmd_vld && m_ptr[m] == 2;
                if (sel && wr_vld && !cmd_vld && m_ptr[m] == 0) m_ie[m] = wr_byte[3:0];
                m_lost[m] = ev_lost[m] || (m_lost[m] && !clr);
                m_init[m] = ev_init[m] || (m_init[m] && !clr);
                if (sel && cmd_vld) begin
                    m_ptr[m] = (cmd_byte[1:0] == 2'b11) ? 2 : int'(cmd_byte[1:0]);
                    m_ai[m]  = cmd_byte[4];
                end else if (sel && (wr_vld || rd_vld) && m_ai[m] && m_ptr[m] < 2) begin
                    m_ptr[m] = m_ptr[m] + 1;
                end
            end
        end
    end

    // R9: every cycle, both lines against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_n !== m_irq) begin
                fails++;
                $display("FAIL R9 irq_n per-cycle: actual=%b expected=%b", irq_n, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit cv, input bit [7:0] cb,
                        input bit wv, input bit [7:0] wb, input bit rv,
                        input bit [1:0] lo, input bit [1:0] in);
        @(negedge clk);
        acc_sel = s; cmd_vld = cv; cmd_byte = cb; wr_vld = wv; wr_byte = wb;
        rd_vld = rv; ev_lost = lo; ev_init = in;
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h0, 0, 8'h0, 0, 2'b00, 2'b00);
    endtask

    task automatic cmd(input bit s, input bit [7:0] b);
        step(s, 1, b, 0, 8'h0, 0, 2'b00, 2'b00);
    endtask

    task automatic wr(input bit s, input bit [7:0] b, input string tag, input bit exp_ack);
        step(s, 0, 8'h0, 1, b, 0, 2'b00, 2'b00);
        chk(tag, {7'b0, wr_ack}, {7'b0, exp_ack});
        chk({tag, " model"}, {7'b0, wr_ack}, {7'b0, (m_ptr[s] != 2)});
    endtask

    task automatic rd(input bit s, input string tag, input bit [7:0] exp);
        step(s, 0, 8'h0, 0, 8'h0, 1, 2'b00, 2'b00);
        chk(tag, rd_byte, exp);
        chk({tag, " model"}, rd_byte, m_rd(s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        chk("R10 reset irq_n", {6'b0, irq_n}, 8'h03);
        cmd(0, 8'h00);
        rd(0, "R10 reset enable", 8'h00);
        cmd(1, 8'h02);
        rd(1, "R10 reset status", 8'h00);

        // auto-increment write from enable register
        cmd(0, 8'h10);
        wr(0, 8'h01, "R3 ack enable", 1);
        wr(0, 8'hA5, "R3 ack control", 1);
        chk("R3 ctl_we", {7'b0, ctl_we}, 8'h01);
        chk("R3 ctl_wd", ctl_wd, 8'hA5);
        wr(0, 8'h33, "R4 third byte nak", 0);
        cmd(0, 8'h00);
        rd(0, "R3 enable readback", 8'h01);
        cmd(0, 8'h01);
        rd(0, "R1 control select", 8'h5A);

        // write to status is refused
        cmd(0, 8'h02);
        wr(0, 8'hFF, "R4 status write nak", 0);
        chk("R4 no ctl_we", {7'b0, ctl_we}, 8'h00);
        cmd(0, 8'h00);
        rd(0, "R4 enable untouched", 8'h01);

        // downstream source, master 0 masked
        ds_irq_n = 1'b0;
        idle(2);
        chk("R6 only master1 low", {6'b0, irq_n}, 8'h01);
        cmd(0, 8'h02);
        rd(0, "R7 ds bit set", 8'h01);
        rd(0, "R7 ds bit kept after read", 8'h01);
        cmd(0, 8'h00);
        wr(0, 8'h00, "R3 unmask", 1);
        idle(2);
        chk("R5 both low", {6'b0, irq_n}, 8'h00);
        ds_irq_n = 1'b1;
        idle(2);
        chk("R9 released", {6'b0, irq_n}, 8'h03);

        // bus lost on master 1
        step(0, 0, 8'h0, 0, 8'h0, 0, 2'b10, 2'b00);
        idle(2);
        chk("R8 lost raises irq", {6'b0, irq_n}, 8'h01);
        cmd(0, 8'h02);
        rd(0, "R8 other master read", 8'h00);
        idle(1);
        chk("R8 not cleared by other", {6'b0, irq_n}, 8'h01);
        cmd(1, 8'h02);
        rd(1, "R8 lost bit", 8'h02);
        idle(2);
        chk("R8 cleared irq", {6'b0, irq_n}, 8'h03);
        rd(1, "R8 lost cleared", 8'h00);

        // event in the same cycle as the clearing read
        cmd(0, 8'h02);
        step(0, 0, 8'h0, 0, 8'h0, 1, 2'b00, 2'b01);
        chk("R8 same-cycle read old", rd_byte, 8'h00);
        rd(0, "R8 event wins", 8'h04);
        rd(0, "R8 then cleared", 8'h00);

        // test level is not cleared by reading
        tst_lvl = 2'b10;
        idle(2);
        chk("R9 test irq", {6'b0, irq_n}, 8'h01);
        cmd(1, 8'h02);
        rd(1, "R7 test bit", 8'h08);
        rd(1, "R7 test bit kept", 8'h08);
        tst_lvl = 2'b00;

        // auto-increment reads saturate
        cmd(1, 8'h10);
        rd(1, "R2 ai read ie", 8'h00);
        rd(1, "R2 ai read ctl", 8'h5A);
        rd(1, "R2 ai read stat", 8'h00);
        rd(1, "R2 ai sticks at stat", 8'h00);
        cmd(1, 8'h13);
        rd(1, "R1 code 11 is status", 8'h00);
        cmd(1, 8'h01);
        rd(1, "R2 no ai first", 8'h5A);
        rd(1, "R2 no ai stays", 8'h5A);

        // full mask on master 1
        cmd(1, 8'h00);
        wr(1, 8'h0F, "R3 mask all", 1);
        ds_irq_n = 1'b0;
        tst_lvl = 2'b10;
        step(0, 0, 8'h0, 0, 8'h0, 0, 2'b10, 2'b00);
        idle(2);
        chk("R9 masked line high", {6'b0, irq_n}, 8'h02);
        ds_irq_n = 1'b1;
        tst_lvl = 2'b00;
        idle(3);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule